// File: doc/BRIEF.md
# Resonant Converter Mode Sequencer

This block is the supervisory state machine of a resonant half-bridge controller. It takes the digital outputs of the supply and shutdown-pin comparators, plus an overcurrent flag sampled from the switch node. From these it decides which of four modes the controller is in: undervoltage lockout, sleep, run or fault. It then drives the enables and discharge commands for the oscillator, the gate drivers, the frequency reference and the startup current source.

The comparator flags pass through a synchronizer of parameterized depth before the state machine uses them. The overcurrent flag counts only while the low-side gate is on and only after a blanking window of a programmable number of clocks. That window restarts on every low-side start pulse from the gate generator. A trip removes the gate enable in the same cycle and latches a fault. Only a full supply undervoltage cycle clears the fault. Entering sleep, undervoltage or fault discharges the soft-start node, so every restart begins with a soft-start sweep.

Top module: `conv_mode_seq`

## Requirements
- R1: During reset and in the undervoltage mode the outputs are {osc_en,gate_en,ref_en,ct_dis,ss_dis,chg_en,lo_hold} = 0000101: gates and oscillator off, low-side held low, soft-start node discharged.
- R2: Undervoltage mode is left only when the supply-above-turn-on flag is high and the supply-below-turn-off flag is low; shutdown-pin flags have no effect there.
- R3: The supply-below-turn-off flag returns the block to undervoltage mode from any mode, with priority over every other input.
- R4: Sleep mode drives 0000110 (startup charge current on, soft-start discharged). A high enable-threshold flag moves it to run mode, which drives 1110000 (oscillator, gates and reference on).
- R5: In run mode the standby-threshold flag moves the block to sleep. While neither shutdown-pin flag is set, run mode is kept (hysteresis band).
- R6: The overcurrent flag has no effect while the low-side output is low, or during the BLANK_CYC clocks after the rising edge that captures a low-side start pulse.
- R7: An overcurrent flag seen with the low-side on and blanking expired clears gate_en in that cycle (1010000). On the next clock the block enters fault mode, which drives 0001100 (both timing nodes discharged).
- R8: Fault mode is latched. Shutdown-pin flags, the turn-on flag and the overcurrent flag do not release it; only the turn-off flag (to undervoltage) followed by the turn-on flag (to sleep) does.
- R9: When an overcurrent trip and a standby request apply in the same cycle in run mode, the block enters fault, not sleep.
- R10: A comparator flag change is acted upon at the third rising clock edge after it is applied: two synchronizer stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_above_on | input | 1 | Supply above turn-on threshold (comparator) |
| vcc_below_off | input | 1 | Supply below turn-off threshold (comparator) |
| sd_above_en | input | 1 | Shutdown-pin level above rising enable threshold |
| sd_below_sby | input | 1 | Shutdown-pin level below standby threshold |
| ocp_flag | input | 1 | Switch-node overcurrent comparator flag |
| lo | input | 1 | Low-side gate state from the gate generator |
| lo_start | input | 1 | One-cycle pulse marking a low-side turn-on |
| osc_en | output | 1 | Oscillator enable |
| gate_en | output | 1 | Gate driver enable |
| ref_en | output | 1 | Frequency reference enable |
| ct_dis | output | 1 | Timing capacitor discharge command |
| ss_dis | output | 1 | Soft-start node discharge command |
| chg_en | output | 1 | Startup charge current enable |
| lo_hold | output | 1 | Actively hold the low-side gate low |

## Verification
The bench builds the block with two synchronizer stages and a blanking count of 4. With those values the three-edge response latency and the end of the blanking window fall on exact, countable cycles. The bench therefore checks gate removal on the very edge the window opens, and the fault entry one edge later. A table of comparator patterns walks all mode transitions, including the hysteresis band and both-flags-high supply cases. Directed tests then cover latency, blanking, the fault latch and the trip-over-sleep ordering.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

   typedef enum logic [1:0] {
      M_UVLO  = 2'd0,
      M_SLEEP = 2'd1,
      M_RUN   = 2'd2,
      M_FAULT = 2'd3
   } mode_e;

   typedef struct packed {
      logic osc_en;
      logic gate_en;
      logic ref_en;
      logic ct_dis;
      logic ss_dis;
      logic chg_en;
      logic lo_hold;
   } drv_s;

   localparam int FLAG_N = 5;

   localparam int F_VON  = 0;
   localparam int F_VOFF = 1;
   localparam int F_SDEN = 2;
   localparam int F_SBY  = 3;
   localparam int F_OCP  = 4;

endpackage

// File: rtl/cseq_sync.sv
module cseq_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cseq_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cseq_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) begin
            stg[i] <= '0;
         end
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/cseq_blank.sv
module cseq_blank #(
   parameter int BLANK_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lo,
   input  logic lo_start,
   output logic win_open,
   output logic blanking
);

   localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC);

   generate
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("cseq_blank: BLANK_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          armed_q;
   logic          cnt_zero;

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (lo_start) begin
            cnt_q   <= LOAD;
            armed_q <= 1'b1;
         end else if (!lo) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
         end else if (!cnt_zero) begin
            cnt_q   <= cnt_q - 1'b1;
         end
      end
   end

   assign win_open = lo && armed_q && cnt_zero;
   assign blanking = !cnt_zero;

endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
   import cseq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  von,
   input  logic  voff,
   input  logic  sden,
   input  logic  sby,
   input  logic  trip,
   output mode_e mode,
   output drv_s  drv
);

   mode_e mode_q;
   mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      if (voff) begin
         mode_d = M_UVLO;
      end else begin
         unique case (mode_q)
            M_UVLO:  if (von)  mode_d = M_SLEEP;
            M_SLEEP: if (sden) mode_d = M_RUN;
            M_RUN: begin
               if (trip)     mode_d = M_FAULT;
               else if (sby) mode_d = M_SLEEP;
            end
            M_FAULT: mode_d = M_FAULT;
            default: mode_d = M_UVLO;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= M_UVLO;
      else        mode_q <= mode_d;
   end

   always_comb begin
      drv = '0;
      unique case (mode_q)
         M_UVLO: begin
            drv.ss_dis  = 1'b1;
            drv.lo_hold = 1'b1;
         end
         M_SLEEP: begin
            drv.ss_dis = 1'b1;
            drv.chg_en = 1'b1;
         end
         M_RUN: begin
            drv.osc_en  = 1'b1;
            drv.gate_en = 1'b1;
            drv.ref_en  = 1'b1;
         end
         M_FAULT: begin
            drv.ct_dis = 1'b1;
            drv.ss_dis = 1'b1;
         end
         default: drv.lo_hold = 1'b1;
      endcase
   end

   assign mode = mode_q;

endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq
   import cseq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BLANK_CYC   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_above_on,
   input  logic vcc_below_off,
   input  logic sd_above_en,
   input  logic sd_below_sby,
   input  logic ocp_flag,
   input  logic lo,
   input  logic lo_start,
   output logic osc_en,
   output logic gate_en,
   output logic ref_en,
   output logic ct_dis,
   output logic ss_dis,
   output logic chg_en,
   output logic lo_hold
);

   logic [FLAG_N-1:0] flag_raw;
   logic [FLAG_N-1:0] flag_s;
   logic              win_open;
   logic              blanking;
   logic              trip;
   mode_e             mode;
   drv_s              drv;

   assign flag_raw[F_VON]  = vcc_above_on;
   assign flag_raw[F_VOFF] = vcc_below_off;
   assign flag_raw[F_SDEN] = sd_above_en;
   assign flag_raw[F_SBY]  = sd_below_sby;
   assign flag_raw[F_OCP]  = ocp_flag;

   cseq_sync #(
      .WIDTH  (FLAG_N),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (flag_raw),
      .q     (flag_s)
   );

   cseq_blank #(
      .BLANK_CYC (BLANK_CYC)
   ) u_blank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lo       (lo),
      .lo_start (lo_start),
      .win_open (win_open),
      .blanking (blanking)
   );

   assign trip = (mode == M_RUN) && win_open && flag_s[F_OCP];

   cseq_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .von   (flag_s[F_VON]),
      .voff  (flag_s[F_VOFF]),
      .sden  (flag_s[F_SDEN]),
      .sby   (flag_s[F_SBY]),
      .trip  (trip),
      .mode  (mode),
      .drv   (drv)
   );

   assign osc_en  = drv.osc_en;
   assign gate_en = drv.gate_en && !trip;
   assign ref_en  = drv.ref_en;
   assign ct_dis  = drv.ct_dis;
   assign ss_dis  = drv.ss_dis;
   assign chg_en  = drv.chg_en;
   assign lo_hold = drv.lo_hold;

endmodule

// File: rtl/cseq_checker.sv
module cseq_checker
   import cseq_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input mode_e mode,
   input logic  voff_s,
   input logic  von_s,
   input logic  trip,
   input logic  blanking,
   input logic  gate_en,
   input logic  osc_en,
   input logic  ref_en,
   input logic  lo_hold,
   input logic  chg_en,
   input logic  ss_dis
);

   AST_UVLO_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_UVLO) |-> (lo_hold && !gate_en && !osc_en)); // R1

   AST_UVLO_EXIT_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == M_UVLO && mode != M_UVLO) |-> $past(von_s)); // R2

   AST_VOFF_TO_UVLO: assert property (@(posedge clk) disable iff (!rst_n)
      voff_s |=> (mode == M_UVLO)); // R3

   AST_GATE_WITH_REF: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en |-> (osc_en && ref_en)); // R4

   AST_SLEEP_CHARGES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SLEEP) |-> (chg_en && ss_dis)); // R4

   AST_NO_TRIP_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
      blanking |-> !trip); // R6

   AST_TRIP_CUTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      trip |-> !gate_en); // R7

   AST_TRIP_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && !voff_s) |=> (mode == M_FAULT)); // R9

   AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_FAULT && !voff_s) |=> (mode == M_FAULT)); // R8

endmodule

bind conv_mode_seq cseq_checker u_cseq_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .voff_s   (flag_s[cseq_pkg::F_VOFF]),
   .von_s    (flag_s[cseq_pkg::F_VON]),
   .trip     (trip),
   .blanking (blanking),
   .gate_en  (gate_en),
   .osc_en   (osc_en),
   .ref_en   (ref_en),
   .lo_hold  (lo_hold),
   .chg_en   (chg_en),
   .ss_dis   (ss_dis)
);

// File: tb/conv_mode_seq_bench.sv
module conv_mode_seq_bench;

   localparam int BLANK = 4;

   localparam logic [6:0] P_UVLO  = 7'b0000101;
   localparam logic [6:0] P_SLEEP = 7'b0000110;
   localparam logic [6:0] P_RUN   = 7'b1110000;
   localparam logic [6:0] P_TRIP  = 7'b1010000;
   localparam logic [6:0] P_FAULT = 7'b0001100;

   // {von, voff, sden, sby, expected outputs}
   localparam int NV = 13;
   localparam logic [10:0] VEC [NV] = '{
      {4'b0000, P_UVLO},
      {4'b0010, P_UVLO},
      {4'b1000, P_SLEEP},
      {4'b1001, P_SLEEP},
      {4'b1010, P_RUN},
      {4'b1000, P_RUN},
      {4'b1001, P_SLEEP},
      {4'b1010, P_RUN},
      {4'b0110, P_UVLO},
      {4'b1110, P_UVLO},
      {4'b1010, P_SLEEP},
      {4'b1010, P_RUN},
      {4'b0010, P_RUN}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vcc_above_on = 1'b0, vcc_below_off = 1'b0;
   logic sd_above_en = 1'b0, sd_below_sby = 1'b0;
   logic ocp_flag = 1'b0, lo = 1'b0, lo_start = 1'b0;
   logic osc_en, gate_en, ref_en, ct_dis, ss_dis, chg_en, lo_hold;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   conv_mode_seq #(.SYNC_STAGES(2), .BLANK_CYC(BLANK)) u_conv_mode_seq (
      .clk, .rst_n, .vcc_above_on, .vcc_below_off, .sd_above_en,
      .sd_below_sby, .ocp_flag, .lo, .lo_start, .osc_en, .gate_en,
      .ref_en, .ct_dis, .ss_dis, .chg_en, .lo_hold
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic setv(input logic [3:0] f);
      {vcc_above_on, vcc_below_off, sd_above_en, sd_below_sby} = f;
   endtask

   task automatic check(input string what, input logic [6:0] exp);
      logic [6:0] got;
      got = {osc_en, gate_en, ref_en, ct_dis, ss_dis, chg_en, lo_hold};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%b exp=%b", what, got, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      summary();
   end

   initial begin
      @(negedge clk);
      check("R1 outputs during reset", P_UVLO);
      step(2);
      rst_n = 1'b1;
      step(1);
      check("R1 outputs after reset", P_UVLO);

      for (int i = 0; i < NV; i++) begin
         setv(VEC[i][10:7]);
         step(3);
         check($sformatf("R2 R3 R4 R5 table entry %0d", i), VEC[i][6:0]);
      end

      // R10: latency of a comparator change
      setv(4'b1001);
      step(2);
      check("R10 no response after two edges", P_RUN);
      step(1);
      check("R10 response at third edge", P_SLEEP);
      setv(4'b1010);
      step(3);
      check("R4 back to run", P_RUN);

      // R6: overcurrent ignored while low side is off
      ocp_flag = 1'b1;
      step(10);
      check("R6 ocp with lo low", P_RUN);

      // R6/R7: blanking then trip
      lo = 1'b1;
      lo_start = 1'b1;
      step(1);
      lo_start = 1'b0;
      step(3);
      check("R6 ocp inside blanking", P_RUN);
      step(1);
      check("R7 gate cut when window opens", P_TRIP);
      step(1);
      check("R7 fault entered", P_FAULT);

      // R8: latched fault
      setv(4'b1001);
      step(4);
      check("R8 standby flag ignored in fault", P_FAULT);
      lo = 1'b0;
      ocp_flag = 1'b0;
      setv(4'b1010);
      step(4);
      check("R8 enable flag ignored in fault", P_FAULT);
      setv(4'b0110);
      step(3);
      check("R8 turn-off releases to uvlo", P_UVLO);
      setv(4'b1000);
      step(3);
      check("R8 turn-on restarts in sleep", P_SLEEP);
      setv(4'b1010);
      step(3);
      check("R4 run after fault recovery", P_RUN);

      // R9: trip and standby together
      lo = 1'b1;
      lo_start = 1'b1;
      step(1);
      lo_start = 1'b0;
      step(BLANK + 1);
      check("R6 window open, no ocp", P_RUN);
      ocp_flag = 1'b1;
      setv(4'b1001);
      step(3);
      check("R9 fault wins over sleep", P_FAULT);

      // R1: reset from fault
      rst_n = 1'b0;
      step(1);
      check("R1 reset clears fault", P_UVLO);
      lo = 1'b0;
      ocp_flag = 1'b0;
      setv(4'b0000);
      rst_n = 1'b1;
      step(3);
      check("R2 stays in uvlo without turn-on", P_UVLO);

      summary();
   end

endmodule